// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block places incoming frames into memory buffers that are chosen from a small ring of receive descriptors. Each descriptor has three fields: a 16-bit status word, a length, and a buffer base address. A frame arrives as a byte stream from the MAC side, with start and end markers and a per-byte error flag. The engine takes the descriptor at its current ring index, but only when that descriptor's empty flag is set. It writes the frame bytes to consecutive buffer addresses and then records the stored length in the descriptor. That length counts every byte presented, including the 4 trailing CRC bytes. The engine also records the error flags, clears the empty flag, and moves to the next descriptor. After the descriptor that carries the wrap flag, it returns to index 0.

If a frame starts while the current descriptor is not empty, the ring is full. The engine raises a busy event, drops that frame and halts reception. Software has two separate actions. It clears the busy event by writing one to it. It lets reception resume by pulsing a halt-clear input. Software owns the ring through a simple descriptor write port and a read port. It re-arms a descriptor by writing the length as zero and setting the empty flag. The block contains no memory bus and no MAC: buffer writes leave through a plain byte write port.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, every descriptor reads back status 0x0000 and length 0. The busy event, the halted flag, the buffer write strobe and the completion pulse are all low, and the ring index is 0.
- R2: For an accepted frame, byte i is written to buffer address base+i, in arrival order. Each byte appears on the buffer port one cycle after it is presented.
- R3: A descriptor is used only while its status bit 15 (empty) is set. On completion the engine writes the length as the count of stored bytes, which includes the CRC. It clears bit 15, keeps bit 13 (wrap), and sets the error bits [1:0] as defined in R6 and R7.
- R4: The descriptor update and a one-cycle frame_done pulse become visible one cycle after the frame's last stored byte appears on the buffer port. No buffer write occurs in the cycle after the update.
- R5: After each completed frame the ring index goes to the next descriptor. After a descriptor with bit 13 set, or after the last entry, it goes to 0.
- R6: If rx_err is high on any byte of a frame, status bit 0 is set. The frame's bytes are still written to the buffer.
- R7: Bytes beyond MAX_LEN are not stored. The length is then MAX_LEN and status bit 1 is set.
- R8: If a frame starts while the current descriptor's bit 15 is clear, ev_busy and rx_halted both go high. Nothing of that frame is stored, and the descriptor is left unchanged.
- R9: While halted, a frame is dropped whole. No buffer write occurs, no descriptor changes, and the ring index stays where it was.
- R10: A pulse on ev_clr clears ev_busy and leaves rx_halted set. Only a pulse on halt_clr clears rx_halted. A new busy condition takes priority over either clear in the same cycle.
- R11: A software write stores the status, length and pointer of the addressed descriptor. The read port returns the status and length of sw_ridx in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A frame byte is present this cycle |
| rx_sof | input | 1 | This byte is the first of a frame |
| rx_eof | input | 1 | This byte is the last of a frame |
| rx_data | input | 8 | Frame byte |
| rx_err | input | 1 | Error seen on this byte |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_widx | input | IDX_W | Descriptor index to write |
| sw_wstatus | input | 16 | Status word to write |
| sw_wlen | input | LEN_W | Length to write |
| sw_wptr | input | ADDR_W | Buffer base address to write |
| sw_ridx | input | IDX_W | Descriptor index to read |
| sw_rstatus | output | 16 | Status word of sw_ridx |
| sw_rlen | output | LEN_W | Length of sw_ridx |
| ev_clr | input | 1 | Write-one pulse clearing the busy event |
| halt_clr | input | 1 | Pulse that lets reception resume |
| ev_busy | output | 1 | Busy event: a frame met a full ring |
| rx_halted | output | 1 | Reception is halted |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | ADDR_W | Buffer byte address |
| buf_wdata | output | 8 | Buffer byte data |
| frame_done | output | 1 | One-cycle pulse when a descriptor is released |

## Verification
The assertions assume a well-formed frame stream. Every rx_sof begins a frame that ends with exactly one rx_eof, and no byte arrives in the cycle after a frame's last byte, while the descriptor is written back. They also assume that software never writes the descriptor the engine is filling. The stimulus sends every frame as back-to-back bytes, leaves several idle cycles between frames, and re-arms a descriptor only once the engine has released it or while reception is halted.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
  localparam int ST_EMPTY = 15;
  localparam int ST_WRAP  = 13;
  localparam int ST_TRUNC = 1;
  localparam int ST_FERR  = 0;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RECV = 2'd1,
    S_WB   = 2'd2,
    S_DROP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rx_ring_desc_file.sv
module rx_ring_desc_file
  import rx_ring_pkg::*;
#(
  parameter int NDESC  = 4,
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 12,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_widx,
  input  logic [15:0]       sw_wstatus,
  input  logic [LEN_W-1:0]  sw_wlen,
  input  logic [ADDR_W-1:0] sw_wptr,
  input  logic [IDX_W-1:0]  sw_ridx,
  output logic [15:0]       sw_rstatus,
  output logic [LEN_W-1:0]  sw_rlen,
  input  logic              eng_we,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [15:0]       eng_status,
  input  logic [LEN_W-1:0]  eng_len,
  output logic [15:0]       cur_status,
  output logic [ADDR_W-1:0] cur_ptr
);
  logic [15:0]       st_q  [NDESC];
  logic [15:0]       st_d  [NDESC];
  logic [LEN_W-1:0]  len_q [NDESC];
  logic [LEN_W-1:0]  len_d [NDESC];
  logic [ADDR_W-1:0] ptr_q [NDESC];
  logic [ADDR_W-1:0] ptr_d [NDESC];

  always_comb begin
    for (int i = 0; i < NDESC; i++) begin
      st_d[i]  = st_q[i];
      len_d[i] = len_q[i];
      ptr_d[i] = ptr_q[i];
      if (sw_we && (sw_widx == IDX_W'(i))) begin
        st_d[i]  = sw_wstatus;
        len_d[i] = sw_wlen;
        ptr_d[i] = sw_wptr;
      end
      if (eng_we && (eng_idx == IDX_W'(i))) begin
        st_d[i]  = eng_status;
        len_d[i] = eng_len;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        st_q[i]  <= '0;
        len_q[i] <= '0;
        ptr_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NDESC; i++) begin
        st_q[i]  <= st_d[i];
        len_q[i] <= len_d[i];
        ptr_q[i] <= ptr_d[i];
      end
    end
  end

  assign sw_rstatus = st_q[sw_ridx];
  assign sw_rlen    = len_q[sw_ridx];
  assign cur_status = st_q[eng_idx];
  assign cur_ptr    = ptr_q[eng_idx];

  // R3
  release_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> !st_q[$past(eng_idx)][ST_EMPTY]);
endmodule

// File: rtl/rx_ring_events.sv
module rx_ring_events (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_hit,
  input  logic ev_clr,
  input  logic halt_clr,
  output logic ev_busy,
  output logic halted
);
  logic busy_q, busy_d;
  logic halt_q, halt_d;

  always_comb begin
    busy_d = busy_q;
    halt_d = halt_q;
    if (ev_clr)   busy_d = 1'b0;
    if (halt_clr) halt_d = 1'b0;
    if (busy_hit) begin
      busy_d = 1'b1;
      halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      halt_q <= halt_d;
    end
  end

  assign ev_busy = busy_q;
  assign halted  = halt_q;

  // R8
  busy_sets_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> halt_q);

  // R10
  halt_only_by_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt_q) |-> $past(halt_clr));
endmodule

// File: rtl/rx_ring_fsm.sv
module rx_ring_fsm
  import rx_ring_pkg::*;
#(
  parameter int NDESC   = 4,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 12,
  parameter int IDX_W   = 2,
  parameter int MAX_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              rx_err,
  input  logic              halted_i,
  input  logic [15:0]       cur_status,
  input  logic [ADDR_W-1:0] cur_ptr,
  output logic [IDX_W-1:0]  idx,
  output logic              eng_we,
  output logic [15:0]       eng_status,
  output logic [LEN_W-1:0]  eng_len,
  output logic              busy_hit,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              frame_done
);
  rx_state_e         state_q, state_d;
  logic [LEN_W-1:0]  cnt_q, cnt_d, st_cnt;
  logic [ADDR_W-1:0] base_q, base_d, st_base;
  logic              trunc_q, trunc_d, err_q, err_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              byte_in, take;
  logic              we_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;

  assign st_cnt  = (state_q == S_IDLE) ? '0 : cnt_q;
  assign st_base = (state_q == S_IDLE) ? cur_ptr : base_q;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    base_d   = base_q;
    trunc_d  = trunc_q;
    err_d    = err_q;
    idx_d    = idx_q;
    byte_in  = 1'b0;
    take     = 1'b0;
    busy_hit = 1'b0;
    eng_we   = 1'b0;
    unique case (state_q)
      S_IDLE: if (rx_valid && rx_sof) begin
        if (halted_i) begin
          state_d = rx_eof ? S_IDLE : S_DROP;
        end else if (!cur_status[ST_EMPTY]) begin
          busy_hit = 1'b1;
          state_d  = rx_eof ? S_IDLE : S_DROP;
        end else begin
          byte_in = 1'b1;
          base_d  = cur_ptr;
          trunc_d = 1'b0;
          err_d   = rx_err;
          state_d = rx_eof ? S_WB : S_RECV;
        end
      end
      S_RECV: if (rx_valid) begin
        byte_in = 1'b1;
        err_d   = err_q | rx_err;
        if (rx_eof) state_d = S_WB;
      end
      S_WB: begin
        eng_we  = 1'b1;
        state_d = S_IDLE;
        if (cur_status[ST_WRAP] || (idx_q == IDX_W'(NDESC - 1))) idx_d = '0;
        else idx_d = idx_q + 1'b1;
      end
      S_DROP: if (rx_valid && rx_eof) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
    if (byte_in) begin
      if (st_cnt < LEN_W'(MAX_LEN)) begin
        take  = 1'b1;
        cnt_d = st_cnt + 1'b1;
      end else begin
        trunc_d = 1'b1;
        cnt_d   = st_cnt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      base_q  <= '0;
      trunc_q <= 1'b0;
      err_q   <= 1'b0;
      idx_q   <= '0;
      we_q    <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      trunc_q <= trunc_d;
      err_q   <= err_d;
      idx_q   <= idx_d;
      we_q    <= take;
      done_q  <= eng_we;
      if (take) begin
        addr_q <= st_base + ADDR_W'(st_cnt);
        data_q <= rx_data;
      end
    end
  end

  always_comb begin
    eng_status = '0;
    eng_status[ST_WRAP]  = cur_status[ST_WRAP];
    eng_status[ST_TRUNC] = trunc_q;
    eng_status[ST_FERR]  = err_q;
  end

  assign eng_len    = cnt_q;
  assign idx        = idx_q;
  assign buf_we     = we_q;
  assign buf_addr   = addr_q;
  assign buf_wdata  = data_q;
  assign frame_done = done_q;

  // R7
  store_in_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> (ADDR_W'(addr_q - base_q) < ADDR_W'(MAX_LEN)));

  // R9
  halt_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && halted_i) |=> !we_q);

  // R4
  status_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |=> !we_q);

  // R4 input rule: no byte during descriptor write-back
  gap_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WB) |-> !rx_valid);
endmodule

// File: rtl/rx_ring_engine.sv
module rx_ring_engine
  import rx_ring_pkg::*;
#(
  parameter int NDESC   = 4,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 12,
  parameter int MAX_LEN = 64,
  localparam int IDX_W  = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic              rx_eof,
  input  logic [7:0]        rx_data,
  input  logic              rx_err,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_widx,
  input  logic [15:0]       sw_wstatus,
  input  logic [LEN_W-1:0]  sw_wlen,
  input  logic [ADDR_W-1:0] sw_wptr,
  input  logic [IDX_W-1:0]  sw_ridx,
  output logic [15:0]       sw_rstatus,
  output logic [LEN_W-1:0]  sw_rlen,
  input  logic              ev_clr,
  input  logic              halt_clr,
  output logic              ev_busy,
  output logic              rx_halted,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_wdata,
  output logic              frame_done
);
  logic [IDX_W-1:0]  idx;
  logic              eng_we, busy_hit, halted;
  logic [15:0]       eng_status, cur_status;
  logic [LEN_W-1:0]  eng_len;
  logic [ADDR_W-1:0] cur_ptr;

  rx_ring_desc_file #(.NDESC(NDESC), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W)) desc_i (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_widx(sw_widx), .sw_wstatus(sw_wstatus), .sw_wlen(sw_wlen),
    .sw_wptr(sw_wptr), .sw_ridx(sw_ridx), .sw_rstatus(sw_rstatus), .sw_rlen(sw_rlen),
    .eng_we(eng_we), .eng_idx(idx), .eng_status(eng_status), .eng_len(eng_len),
    .cur_status(cur_status), .cur_ptr(cur_ptr)
  );

  rx_ring_fsm #(.NDESC(NDESC), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .IDX_W(IDX_W),
                .MAX_LEN(MAX_LEN)) fsm_i (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_data(rx_data),
    .rx_err(rx_err), .halted_i(halted), .cur_status(cur_status), .cur_ptr(cur_ptr),
    .idx(idx), .eng_we(eng_we), .eng_status(eng_status), .eng_len(eng_len),
    .busy_hit(busy_hit), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .frame_done(frame_done)
  );

  rx_ring_events ev_i (
    .clk(clk), .rst_n(rst_n), .busy_hit(busy_hit), .ev_clr(ev_clr),
    .halt_clr(halt_clr), .ev_busy(ev_busy), .halted(halted)
  );

  assign rx_halted = halted;
endmodule

// File: tb/rx_ring_engine_tb_top.sv
module rx_ring_engine_tb_top;
  localparam int ND = 4, AW = 16, LW = 12, MAXL = 64, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
  logic [7:0] rx_data = 0;
  logic sw_we = 0;
  logic [IW-1:0] sw_widx = 0, sw_ridx = 0;
  logic [15:0] sw_wstatus = 0;
  logic [LW-1:0] sw_wlen = 0;
  logic [AW-1:0] sw_wptr = 0;
  logic ev_clr = 0, halt_clr = 0;
  logic [15:0] sw_rstatus;
  logic [LW-1:0] sw_rlen;
  logic ev_busy, rx_halted, buf_we, frame_done;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_wdata;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  rx_ring_engine #(.NDESC(ND), .ADDR_W(AW), .LEN_W(LW), .MAX_LEN(MAXL)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .rx_data(rx_data), .rx_err(rx_err), .sw_we(sw_we), .sw_widx(sw_widx),
    .sw_wstatus(sw_wstatus), .sw_wlen(sw_wlen), .sw_wptr(sw_wptr), .sw_ridx(sw_ridx),
    .sw_rstatus(sw_rstatus), .sw_rlen(sw_rlen), .ev_clr(ev_clr), .halt_clr(halt_clr),
    .ev_busy(ev_busy), .rx_halted(rx_halted), .buf_we(buf_we), .buf_addr(buf_addr),
    .buf_wdata(buf_wdata), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int m_st[ND], m_len[ND], m_ptr[ND];
  int m_cur, m_mode, m_cnt, m_base;
  bit m_tr, m_er, m_busy, m_halt;
  bit e_we, e_done;
  int e_addr, e_data;

  always @(posedge clk) begin
    bit set_busy;
    if (!rst_n) begin
      foreach (m_st[i]) begin m_st[i] = 0; m_len[i] = 0; m_ptr[i] = 0; end
      m_cur = 0; m_mode = 0; m_cnt = 0; m_base = 0;
      m_tr = 0; m_er = 0; m_busy = 0; m_halt = 0;
      e_we = 0; e_done = 0; e_addr = 0; e_data = 0;
    end else begin
      set_busy = 0;
      e_we = 0;
      e_done = 0;
      if (sw_we) begin
        m_st[sw_widx] = sw_wstatus; m_len[sw_widx] = sw_wlen; m_ptr[sw_widx] = sw_wptr;
      end
      if (m_mode == 0) begin
        if (rx_valid && rx_sof) begin
          if (m_halt) m_mode = rx_eof ? 0 : 3;
          else if (m_st[m_cur][15] == 0) begin
            set_busy = 1; m_mode = rx_eof ? 0 : 3;
          end else begin
            m_base = m_ptr[m_cur]; m_cnt = 0; m_tr = 0; m_er = rx_err;
            if (m_cnt < MAXL) begin
              e_we = 1; e_addr = (m_base + m_cnt) & 16'hffff; e_data = rx_data; m_cnt++;
            end else m_tr = 1;
            m_mode = rx_eof ? 2 : 1;
          end
        end
      end else if (m_mode == 1) begin
        if (rx_valid) begin
          m_er = m_er | rx_err;
          if (m_cnt < MAXL) begin
            e_we = 1; e_addr = (m_base + m_cnt) & 16'hffff; e_data = rx_data; m_cnt++;
          end else m_tr = 1;
          if (rx_eof) m_mode = 2;
        end
      end else if (m_mode == 2) begin
        m_st[m_cur] = (m_st[m_cur] & 16'h2000) | (m_tr ? 2 : 0) | (m_er ? 1 : 0);
        m_len[m_cur] = m_cnt;
        e_done = 1;
        if ((m_st[m_cur] & 16'h2000) != 0 || m_cur == ND - 1) m_cur = 0;
        else m_cur = m_cur + 1;
        m_mode = 0;
      end else begin
        if (rx_valid && rx_eof) m_mode = 0;
      end
      if (ev_clr) m_busy = 0;
      if (halt_clr) m_halt = 0;
      if (set_busy) begin m_busy = 1; m_halt = 1; end
    end
  end

  // Per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk(buf_we == e_we, "R2 buf_we", buf_we, e_we);
      if (e_we) begin
        chk(buf_addr == e_addr[AW-1:0], "R2 buf_addr", buf_addr, e_addr);
        chk(buf_wdata == e_data[7:0], "R2 buf_wdata", buf_wdata, e_data);
      end
      chk(frame_done == e_done, "R4 frame_done", frame_done, e_done);
      chk(ev_busy == m_busy, "R8 ev_busy", ev_busy, m_busy);
      chk(rx_halted == m_halt, "R10 rx_halted", rx_halted, m_halt);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int id, input int n, input int errpos);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == n - 1);
      rx_data = 8'((id << 4) + i); rx_err = (i == errpos);
    end
    @(negedge clk);
    rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0;
    idle(3);
  endtask

  task automatic arm(input int idx, input int st, input int ptr);
    @(negedge clk);
    sw_we = 1; sw_widx = IW'(idx); sw_wstatus = 16'(st); sw_wlen = '0; sw_wptr = AW'(ptr);
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic rd(input int idx, input int est, input int elen, input string tag);
    @(negedge clk);
    sw_ridx = IW'(idx);
    #1;
    chk(sw_rstatus == 16'(est), {tag, " status"}, sw_rstatus, est);
    chk(sw_rlen == LW'(elen), {tag, " length"}, sw_rlen, elen);
  endtask

  task automatic pulse_evclr();
    @(negedge clk); ev_clr = 1;
    @(negedge clk); ev_clr = 0;
  endtask

  task automatic pulse_haltclr();
    @(negedge clk); halt_clr = 1;
    @(negedge clk); halt_clr = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    #2 rst_n = 1;
    // R1 reset state
    chk(!ev_busy && !rx_halted && !buf_we && !frame_done, "R1 outputs", 0, 0);
    for (int i = 0; i < ND; i++) rd(i, 0, 0, "R1 desc");
    // R11 arm ring, last entry wraps
    arm(0, 16'h8000, 16'h0000);
    arm(1, 16'h8000, 16'h0100);
    arm(2, 16'h8000, 16'h0200);
    arm(3, 16'hA000, 16'h0300);
    rd(3, 16'hA000, 0, "R11 readback");
    // R2 R3 plain frame
    send_frame(1, 10, -1);
    rd(0, 16'h0000, 10, "R3 desc0");
    // R6 error mid-frame, data still stored
    send_frame(2, 5, 2);
    rd(1, 16'h0001, 5, "R6 desc1");
    // R7 oversized frame truncated
    send_frame(3, 70, -1);
    rd(2, 16'h0002, MAXL, "R7 desc2");
    // R5 single-byte frame on wrap entry
    send_frame(4, 1, -1);
    rd(3, 16'h2000, 1, "R5 desc3 wrap kept");
    // R8 ring full: index is back at 0, desc0 not empty
    send_frame(5, 4, -1);
    chk(ev_busy && rx_halted, "R8 busy and halt", {ev_busy, rx_halted}, 3);
    rd(0, 16'h0000, 10, "R8 desc0 unchanged");
    // R9 dropped while halted even after re-arm
    arm(0, 16'h8000, 16'h0040);
    send_frame(6, 6, -1);
    rd(0, 16'h8000, 0, "R9 desc0 untouched");
    // R10 busy clear keeps halt
    pulse_evclr();
    @(negedge clk);
    chk(!ev_busy && rx_halted, "R10 clear busy only", {ev_busy, rx_halted}, 1);
    send_frame(7, 3, 0);
    rd(0, 16'h8000, 0, "R9 still dropped");
    pulse_haltclr();
    @(negedge clk);
    chk(!rx_halted, "R10 halt cleared", rx_halted, 0);
    // R5 resumes at index 0 after wrap
    send_frame(8, 7, -1);
    rd(0, 16'h0000, 7, "R5 desc0 after wrap");
    for (int i = 0; i < ND; i++) rd(i, m_st[i], m_len[i], "R3 model match");
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule